// File: doc/BRIEF.md
# Synthesizer Control Word Register Front End

This block holds the divider settings of a frequency synthesizer and takes them in through one of three interface modes. In serial mode, bits arrive on a data pin and are taken on each rising edge of a serial clock pin. In parallel mode, a byte bus is written into individual fields by dedicated write strobes. In direct mode, the divider values come straight from strap pins. The block keeps a 20-bit primary control word, a 20-bit secondary (hop) control word and an 8-bit enhancement word. Each control word holds a prescaler enable, a 9-bit M count, a 6-bit R count and a 4-bit A count.

A hop strobe copies the primary word into the secondary word. Software can therefore prepare the next channel in the primary word while the secondary word drives the counters, and then switch over. A select input chooses which word feeds the counter outputs. Every strobe and the serial clock pass through a synchronizer into one system clock domain, where their rising edges are detected. The data pins pass through a synchronizer of the same depth.

Top module: `synth_ctrl_regs`

## Requirements
- R1: While rst_ni is low, and after it is released, every stored word is zero. With bmode_i low, m_o, r_o, a_o, pre_en_o and enh_o all read zero.
- R2: With bmode_i=1 the block is in direct mode. m_o, a_o and pre_en_o follow dir_m_i, dir_a_i and dir_pre_en_i combinationally, and r_o still shows the word chosen by fsel_i. With bmode_i=0, smode_i=1 selects serial mode and smode_i=0 selects parallel mode.
- R3: In serial mode with ewr_i low, each rising edge of sclk_i shifts sdata_i into the primary word MSB first. The 20-bit word is ordered {pre_en, M[8:0], R[5:0], A[3:0]} from bit 19 down to bit 0, so pre_en is shifted first.
- R4: In serial mode with ewr_i high, each sclk_i rising edge shifts sdata_i MSB first into the enhancement word, and the primary word is left unchanged.
- R5: In parallel mode, a rising edge on ewr_i loads d_i[7:0] into the enhancement word.
- R6: In parallel mode, a rising edge on m1_wr_i loads d_i[7] into pre_en and d_i[6:0] into M[6:0]. All other primary fields are kept.
- R7: In parallel mode, a rising edge on m2_wr_i loads d_i[3:2] into R[5:4] and d_i[1:0] into M[8:7]. d_i[7:4] is ignored and all other fields are kept.
- R8: In parallel mode, a rising edge on a_wr_i loads d_i[7:4] into R[3:0] and d_i[3:0] into A[3:0]. All other fields are kept.
- R9: In serial or parallel mode, a rising edge on hop_wr_i copies the whole primary word into the secondary word.
- R10: fsel_i=1 routes the primary word to pre_en_o, m_o, r_o and a_o, and fsel_i=0 routes the secondary word. The choice is combinational.
- R11: In direct mode, every strobe and the serial clock are ignored. The primary, secondary and enhancement words keep their values.
- R12: In serial mode, the field strobes m1_wr_i, m2_wr_i and a_wr_i have no effect. In parallel mode, sclk_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bmode_i | input | 1 | Direct mode select |
| smode_i | input | 1 | Serial (1) or parallel (0) when not direct |
| fsel_i | input | 1 | Output word select: 1 primary, 0 secondary |
| sclk_i | input | 1 | Serial shift clock |
| sdata_i | input | 1 | Serial data, MSB first |
| ewr_i | input | 1 | Enhancement write enable (serial) or strobe (parallel) |
| m1_wr_i | input | 1 | Strobe for {pre_en, M[6:0]} |
| m2_wr_i | input | 1 | Strobe for {R[5:4], M[8:7]} |
| a_wr_i | input | 1 | Strobe for {R[3:0], A[3:0]} |
| hop_wr_i | input | 1 | Copy primary word to secondary word |
| d_i | input | 8 | Parallel data bus |
| dir_m_i | input | 9 | Direct-mode M count |
| dir_a_i | input | 4 | Direct-mode A count |
| dir_pre_en_i | input | 1 | Direct-mode prescaler enable (active low) |
| m_o | output | 9 | M count to counters |
| r_o | output | 6 | R count to counters |
| a_o | output | 4 | A count to counters |
| pre_en_o | output | 1 | Prescaler enable, active low; high bypasses the prescaler |
| enh_o | output | 8 | Enhancement word |

## Verification
A rising edge on a strobe or on sclk_i reaches the stored words at the third system clock edge after the pin changes: two synchronizer stages, then the edge-detect register. The data pins pass through a synchronizer of the same depth, so the bench sets them two cycles before raising the strobe. It holds each strobe level for four cycles and samples at a falling edge only after the low phase has also settled. The fsel_i select and the direct-mode outputs are combinational, so they are checked one falling edge after their inputs change.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;
  localparam int M_W    = 9;
  localparam int R_W    = 6;
  localparam int A_W    = 4;
  localparam int ENH_W  = 8;
  localparam int BUS_W  = 8;
  localparam int WORD_W = 1 + M_W + R_W + A_W;

  // strobe vector positions
  localparam int STB_SCLK = 0;
  localparam int STB_EWR  = 1;
  localparam int STB_M1   = 2;
  localparam int STB_M2   = 3;
  localparam int STB_A    = 4;
  localparam int STB_HOP  = 5;
  localparam int NUM_STB  = 6;

  typedef struct packed {
    logic           pre_en;
    logic [M_W-1:0] m;
    logic [R_W-1:0] r;
    logic [A_W-1:0] a;
  } ctrl_word_t;

  typedef enum logic [1:0] {
    MODE_PAR = 2'd0,
    MODE_SER = 2'd1,
    MODE_DIR = 2'd2
  } if_mode_e;

  function automatic if_mode_e decode_mode(input logic bmode, input logic smode);
    if (bmode)      return MODE_DIR;
    else if (smode) return MODE_SER;
    else            return MODE_PAR;
  endfunction
endpackage

// File: rtl/synth_sync.sv
module synth_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/synth_edge.sv
module synth_edge #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl, prev_q;

  synth_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl;
  end

  assign rise_o = lvl & ~prev_q;

  // R9 one pulse per edge, so one hop or shift per strobe
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/synth_word_regs.sv
module synth_word_regs
  import synth_ctrl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  if_mode_e           mode_i,
  input  logic [NUM_STB-1:0] rise_i,
  input  logic               ewr_i,
  input  logic               sdata_i,
  input  logic [BUS_W-1:0]   d_i,
  output ctrl_word_t         prim_o,
  output ctrl_word_t         sec_o,
  output logic [ENH_W-1:0]   enh_o
);
  ctrl_word_t       prim_q, prim_d, sec_q, sec_d;
  logic [ENH_W-1:0] enh_q, enh_d;

  always_comb begin
    prim_d = prim_q;
    sec_d  = sec_q;
    enh_d  = enh_q;
    case (mode_i)
      MODE_SER: begin
        if (rise_i[STB_SCLK]) begin
          if (ewr_i) enh_d  = {enh_q[ENH_W-2:0], sdata_i};
          else       prim_d = ctrl_word_t'({prim_q[WORD_W-2:0], sdata_i});
        end
      end
      MODE_PAR: begin
        if (rise_i[STB_M1]) begin
          prim_d.pre_en        = d_i[BUS_W-1];
          prim_d.m[M_W-3:0]    = d_i[BUS_W-2:0];
        end
        if (rise_i[STB_M2]) begin
          prim_d.r[R_W-1:R_W-2] = d_i[3:2];
          prim_d.m[M_W-1:M_W-2] = d_i[1:0];
        end
        if (rise_i[STB_A]) begin
          prim_d.r[A_W-1:0] = d_i[BUS_W-1:A_W];
          prim_d.a          = d_i[A_W-1:0];
        end
        if (rise_i[STB_EWR]) enh_d = d_i;
      end
      default: ;
    endcase
    // hop takes the word as it stood before this cycle's writes
    if (mode_i != MODE_DIR && rise_i[STB_HOP]) sec_d = prim_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prim_q <= '0;
      sec_q  <= '0;
      enh_q  <= '0;
    end else begin
      prim_q <= prim_d;
      sec_q  <= sec_d;
      enh_q  <= enh_d;
    end
  end

  assign prim_o = prim_q;
  assign sec_o  = sec_q;
  assign enh_o  = enh_q;

  // R9
  hop_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_DIR && rise_i[STB_HOP]) |=> (sec_q == $past(prim_q)));

  // R11
  direct_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DIR) |=> ($stable(prim_q) && $stable(sec_q) && $stable(enh_q)));

  // R5
  enh_par_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PAR && rise_i[STB_EWR]) |=> (enh_q == $past(d_i)));

  // R4
  ser_enh_keeps_prim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SER && ewr_i) |=> $stable(prim_q));

  // R12
  par_no_field_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PAR && !rise_i[STB_M1] && !rise_i[STB_M2] && !rise_i[STB_A])
      |=> $stable(prim_q));
endmodule

// File: rtl/synth_ctrl_regs.sv
module synth_ctrl_regs
  import synth_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bmode_i,
  input  logic             smode_i,
  input  logic             fsel_i,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             ewr_i,
  input  logic             m1_wr_i,
  input  logic             m2_wr_i,
  input  logic             a_wr_i,
  input  logic             hop_wr_i,
  input  logic [BUS_W-1:0] d_i,
  input  logic [M_W-1:0]   dir_m_i,
  input  logic [A_W-1:0]   dir_a_i,
  input  logic             dir_pre_en_i,
  output logic [M_W-1:0]   m_o,
  output logic [R_W-1:0]   r_o,
  output logic [A_W-1:0]   a_o,
  output logic             pre_en_o,
  output logic [ENH_W-1:0] enh_o
);
  localparam int DATA_W = BUS_W + 2;

  if_mode_e           mode;
  logic [NUM_STB-1:0] stb_pins, stb_rise;
  logic [DATA_W-1:0]  data_s;
  ctrl_word_t         prim_w, sec_w, sel_w;

  assign mode = decode_mode(bmode_i, smode_i);

  always_comb begin
    stb_pins           = '0;
    stb_pins[STB_SCLK] = sclk_i;
    stb_pins[STB_EWR]  = ewr_i;
    stb_pins[STB_M1]   = m1_wr_i;
    stb_pins[STB_M2]   = m2_wr_i;
    stb_pins[STB_A]    = a_wr_i;
    stb_pins[STB_HOP]  = hop_wr_i;
  end

  synth_edge #(.W(NUM_STB), .STAGES(SYNC_STAGES)) u_stb_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (stb_pins),
    .rise_o(stb_rise)
  );

  // same depth as the strobes so data lines up with the detected edge
  synth_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_data_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ewr_i, sdata_i, d_i}),
    .q_o   (data_s)
  );

  synth_word_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .rise_i (stb_rise),
    .ewr_i  (data_s[DATA_W-1]),
    .sdata_i(data_s[BUS_W]),
    .d_i    (data_s[BUS_W-1:0]),
    .prim_o (prim_w),
    .sec_o  (sec_w),
    .enh_o  (enh_o)
  );

  assign sel_w = fsel_i ? prim_w : sec_w;

  always_comb begin
    r_o = sel_w.r;
    if (mode == MODE_DIR) begin
      m_o      = dir_m_i;
      a_o      = dir_a_i;
      pre_en_o = dir_pre_en_i;
    end else begin
      m_o      = sel_w.m;
      a_o      = sel_w.a;
      pre_en_o = sel_w.pre_en;
    end
  end
endmodule

// File: tb/synth_ctrl_regs_tb.sv
`timescale 1ns/1ps
module synth_ctrl_regs_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bmode = 1'b0, smode = 1'b0, fsel = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, ewr = 1'b0;
  logic m1 = 1'b0, m2 = 1'b0, aw = 1'b0, hop = 1'b0;
  logic [7:0] d = '0;
  logic [8:0] dir_m = '0;
  logic [3:0] dir_a = '0;
  logic dir_pre = 1'b0;
  logic [8:0] m_o;
  logic [5:0] r_o;
  logic [3:0] a_o;
  logic pre_en_o;
  logic [7:0] enh_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  synth_ctrl_regs u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bmode_i(bmode), .smode_i(smode), .fsel_i(fsel),
    .sclk_i(sclk), .sdata_i(sdata), .ewr_i(ewr), .m1_wr_i(m1), .m2_wr_i(m2),
    .a_wr_i(aw), .hop_wr_i(hop), .d_i(d), .dir_m_i(dir_m), .dir_a_i(dir_a),
    .dir_pre_en_i(dir_pre), .m_o(m_o), .r_o(r_o), .a_o(a_o), .pre_en_o(pre_en_o),
    .enh_o(enh_o)
  );

  // op: 0 m1, 1 m2, 2 a, 3 ewr; exp: primary word, or enh in [7:0] for op 3
  localparam logic [30:0] VEC [7] = '{
    {3'd0, 8'hA5, 20'h89400},
    {3'd1, 8'hFE, 20'hC9700},
    {3'd2, 8'h9C, 20'hC979C},
    {3'd3, 8'h3C, 20'h0003C},
    {3'd0, 8'h00, 20'h4039C},
    {3'd1, 8'hF1, 20'h2009C},
    {3'd2, 8'h5A, 20'h2005A}
  };

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] word_out();
    return {pre_en_o, m_o, r_o, a_o};
  endfunction

  task automatic set_stb(input int op, input logic v);
    case (op)
      0: m1 = v;
      1: m2 = v;
      2: aw = v;
      3: ewr = v;
      4: hop = v;
      default: sclk = v;
    endcase
  endtask

  task automatic strobe(input int op, input logic [7:0] data);
    d = data;
    ticks(2);
    set_stb(op, 1'b1);
    ticks(4);
    set_stb(op, 1'b0);
    ticks(4);
  endtask

  task automatic shift_bit(input logic b);
    sdata = b;
    ticks(2);
    sclk = 1'b1;
    ticks(3);
    sclk = 1'b0;
    ticks(3);
  endtask

  initial begin
    logic [19:0] sword;
    sword = 20'hABCDE;
    ticks(3);
    // R1
    check("R1 word in reset", {12'd0, word_out()}, 32'h0);
    check("R1 enh in reset", {24'd0, enh_o}, 32'h0);
    rst_ni = 1'b1;
    ticks(3);
    check("R1 word after reset", {12'd0, word_out()}, 32'h0);

    // parallel table: R5 R6 R7 R8
    for (int i = 0; i < 7; i++) begin
      strobe(int'(VEC[i][30:28]), VEC[i][27:20]);
      case (VEC[i][30:28])
        3'd0: check("R6 m1 write", {12'd0, word_out()}, {12'd0, VEC[i][19:0]});
        3'd1: check("R7 m2 write", {12'd0, word_out()}, {12'd0, VEC[i][19:0]});
        3'd2: check("R8 a write", {12'd0, word_out()}, {12'd0, VEC[i][19:0]});
        default: check("R5 enh parallel", {24'd0, enh_o}, {24'd0, VEC[i][7:0]});
      endcase
    end

    // R9 hop in parallel mode, R10 select
    strobe(4, 8'h00);
    fsel = 1'b0; ticks(1);
    check("R9 hop parallel", {12'd0, word_out()}, 32'h2005A);
    fsel = 1'b1;
    strobe(2, 8'h77);
    check("R10 fsel primary", {12'd0, word_out()}, 32'h20077);
    fsel = 1'b0; ticks(1);
    check("R10 fsel secondary", {12'd0, word_out()}, 32'h2005A);
    fsel = 1'b1;

    // serial: R3 R4 R9 R12
    smode = 1'b1; ticks(2);
    for (int i = 19; i >= 0; i--) shift_bit(sword[i]);
    ticks(2);
    check("R3 serial primary", {12'd0, word_out()}, {12'd0, sword});
    strobe(4, 8'h00);
    fsel = 1'b0; ticks(1);
    check("R9 hop serial", {12'd0, word_out()}, {12'd0, sword});
    fsel = 1'b1;
    ewr = 1'b1; ticks(2);
    for (int i = 7; i >= 0; i--) shift_bit(i[0] ^ i[2] ? 1'b1 : 1'b0);
    ewr = 1'b0; ticks(4);
    check("R4 serial enh", {24'd0, enh_o}, 32'h5A);
    check("R4 primary kept", {12'd0, word_out()}, {12'd0, sword});
    strobe(0, 8'hFF);
    strobe(2, 8'h00);
    check("R12 field strobe in serial", {12'd0, word_out()}, {12'd0, sword});

    smode = 1'b0; ticks(2);
    shift_bit(1'b1);
    shift_bit(1'b0);
    check("R12 sclk in parallel", {12'd0, word_out()}, {12'd0, sword});

    // R2 direct outputs
    dir_m = 9'h1B3; dir_a = 4'h5; dir_pre = 1'b1;
    bmode = 1'b1; ticks(1);
    check("R2 direct m", {23'd0, m_o}, 32'h1B3);
    check("R2 direct a", {28'd0, a_o}, 32'h5);
    check("R2 direct pre_en", {31'd0, pre_en_o}, 32'h1);
    check("R2 direct r from word", {26'd0, r_o}, {26'd0, sword[9:4]});
    dir_pre = 1'b0; dir_m = 9'h042; ticks(1);
    check("R2 direct follows pins", {22'd0, pre_en_o, m_o}, 32'h042);

    // R11 strobes ignored in direct mode
    ticks(2);
    strobe(0, 8'h11);
    strobe(1, 8'h22);
    strobe(2, 8'h33);
    strobe(3, 8'h44);
    shift_bit(1'b1);
    bmode = 1'b0; smode = 1'b0; ticks(2);
    strobe(4, 8'h00);
    bmode = 1'b1; ticks(2);
    strobe(1, 8'h0F);
    bmode = 1'b0; ticks(2);
    check("R11 primary kept", {12'd0, word_out()}, {12'd0, sword});
    fsel = 1'b0; ticks(1);
    check("R11 secondary kept", {12'd0, word_out()}, {12'd0, sword});
    check("R11 enh kept", {24'd0, enh_o}, 32'h5A);
    fsel = 1'b1;

    // R1 reset in mid-run
    rst_ni = 1'b0; ticks(1);
    check("R1 mid-run reset word", {12'd0, word_out()}, 32'h0);
    check("R1 mid-run reset enh", {24'd0, enh_o}, 32'h0);
    rst_ni = 1'b1; ticks(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule